// File: doc/BRIEF.md
# Speed-Paced Transmit Byte Acceptor

This block sits on the MAC side of a byte-wide AXI4-Stream transmit interface and decides on which clock edges frame bytes are taken from the client. The clock stays at one fixed frequency at every line rate. The block lowers the effective byte rate by asserting `s_tready` only once in every 1, 10 or 100 cycles, according to a two-bit speed setting.

A frame starts with a prefill. The block takes the first two bytes back to back at full clock rate, whatever the speed. It then holds `s_tready` low until `tx_permit` is seen high. After that it takes the rest of the frame at the paced rate. Addresses and length/type travel in-band at the head of the byte stream and pass through unchanged.

Each byte taken is presented one cycle later on the line-side outputs, together with a strobe, a start-of-frame flag and an end-of-frame flag. If the client has no byte ready at a paced slot, that slot is lost and the frame is marked as underrun.

Top module: `tx_pacer`

## Requirements
- R1: After reset `s_tready` is high while the block is idle, and `o_strobe`, `o_sof`, `o_eof` and `o_underrun` are low.
- R2: The first two bytes of every frame are taken on consecutive clock edges at every speed setting.
- R3: After the second byte is taken, `s_tready` stays low until `tx_permit` has been observed high.
- R4: A byte is taken only on an edge where `s_tvalid` and `s_tready` are both high. Each byte taken appears on `o_data` with `o_strobe` high one cycle later, unchanged and in order.
- R5: `o_sof` is high with the strobe of a frame's first byte. `o_eof` is high with the strobe of the byte that carried `s_tlast`.
- R6: Speed code 0 gives a paced period of 1 cycle, code 1 gives DIV_MID (10), and codes 2 and 3 give DIV_LOW (100). With `tx_permit` already high, byte three is taken period+1 cycles after byte two. Every later byte is taken exactly one period after the byte before it.
- R7: If `s_tvalid` is low during a paced slot, that slot is lost, the window restarts and `o_underrun` goes high. `o_underrun` clears when the next frame's first byte is taken.
- R8: `speed_sel` is sampled only when a frame's first byte is taken. A change during a frame does not alter that frame's pacing.
- R9: On the cycle after the byte carrying `s_tlast` is taken, `s_tready` is low. On the cycle after that, the block is idle with `s_tready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | 0: full rate, 1: one in DIV_MID, 2/3: one in DIV_LOW |
| tx_permit | input | 1 | Transmission may proceed past the prefill |
| s_tdata | input | DATA_W | Client byte |
| s_tvalid | input | 1 | Client byte valid |
| s_tlast | input | 1 | Client byte is the frame's last |
| s_tready | output | 1 | Block takes the byte on this edge |
| o_data | output | DATA_W | Byte toward the line encoder |
| o_strobe | output | 1 | `o_data` holds a new byte |
| o_sof | output | 1 | Byte is a frame's first |
| o_eof | output | 1 | Byte is a frame's last |
| o_underrun | output | 1 | A paced slot of the current frame was missed |

## Verification
Most internal faults in this block show up as a wrong spacing between accepted bytes. A pacing counter with a bad limit or a bad restart moves the third and later bytes by at least one cycle, and this is visible at the first paced slot of a frame. A stuck state shows up at the same time: the prefill runs slow, bytes are taken before `tx_permit`, or the idle cycle after the last byte is missing. The scoreboard also catches lost, repeated or mislabelled bytes one cycle after they cross the interface.

// File: rtl/tx_pacer.sv
module tx_pacer #(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 10,
  parameter int DIV_LOW = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed_sel,
  input  logic              tx_permit,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic [DATA_W-1:0] o_data,
  output logic              o_strobe,
  output logic              o_sof,
  output logic              o_eof,
  output logic              o_underrun
);

  localparam int CNT_W = $clog2(DIV_LOW + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_WAIT, ST_RUN, ST_GAP} st_t;

  st_t              state;
  logic [1:0]       spd_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period;
  logic             slot;
  logic             xfer;

  assign period = (spd_q == 2'd0) ? CNT_W'(1) :
                  (spd_q == 2'd1) ? CNT_W'(DIV_MID) : CNT_W'(DIV_LOW);
  assign slot   = (cnt == period - CNT_W'(1));

  assign s_tready = rst_n && ((state == ST_IDLE) || (state == ST_PRE) ||
                              ((state == ST_RUN) && slot));
  assign xfer     = s_tvalid && s_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      spd_q      <= 2'd0;
      cnt        <= '0;
      o_underrun <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (xfer) begin
          spd_q      <= speed_sel;
          o_underrun <= 1'b0;
          state      <= s_tlast ? ST_GAP : ST_PRE;
        end
        ST_PRE: if (xfer) state <= s_tlast ? ST_GAP : ST_WAIT;
        ST_WAIT: if (tx_permit) begin
          cnt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (slot) begin
            cnt <= '0;
            if (!s_tvalid) o_underrun <= 1'b1;
            else if (s_tlast) state <= ST_GAP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_data   <= '0;
      o_strobe <= 1'b0;
      o_sof    <= 1'b0;
      o_eof    <= 1'b0;
    end else begin
      o_strobe <= xfer;
      o_sof    <= xfer && (state == ST_IDLE);
      o_eof    <= xfer && s_tlast;
      if (xfer) o_data <= s_tdata;
    end
  end

  p_strobe_follows_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) |=> (o_strobe && o_data == $past(s_tdata)));

  p_no_strobe_without_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_tvalid && s_tready) |=> !o_strobe);

  p_flags_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_sof || o_eof) |-> o_strobe);

  p_wait_for_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !tx_permit) |=> (state == ST_WAIT && !s_tready));

  p_gap_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> !s_tready);

  p_paced_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && s_tready && spd_q != 2'd0) |=> !s_tready);

  p_speed_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(spd_q));

  p_underrun_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && s_tready && !s_tvalid) |=> o_underrun);

endmodule

// File: tb/tb_tx_pacer.sv
module tb_tx_pacer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] speed_sel = 0;
  logic       tx_permit = 1;
  logic [7:0] s_tdata = 0;
  logic       s_tvalid = 0;
  logic       s_tlast = 0;
  logic       s_tready;
  logic [7:0] o_data;
  logic       o_strobe, o_sof, o_eof, o_underrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [9:0] expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_pacer dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && o_strobe) begin
      if (expq.size() == 0) chk(0, "R4 unexpected strobe", o_data, -1);
      else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({o_sof, o_eof, o_data} == e, "R4/R5 byte sof eof", {o_sof, o_eof, o_data}, e);
      end
    end
  end

  // Starts and ends at a negedge. per: expected period. drop: index before which a slot is skipped (-1 none).
  // chk2: check the third byte's timing against a permit that is already high.
  task automatic send_frame(input int len, input int base, input int per,
                            input int drop, input bit chk2, input bit spd_flip);
    int tprev = 0;
    for (int i = 0; i < len; i++) begin
      int t;
      if (i == drop) begin
        s_tvalid = 0;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
      end
      s_tvalid = 1;
      s_tdata  = 8'(base + i);
      s_tlast  = (i == len - 1);
      while (!s_tready) begin
        @(negedge clk);
      end
      if (i >= 2 && !tx_permit) chk(0, "R3 taken before permit", i, -1);
      t = cyc;
      expq.push_back({(i == 0), (i == len - 1), 8'(base + i)});
      if (i == 1) chk(t - tprev == 1, "R2 prefill spacing", t - tprev, 1);
      if (i == 2 && chk2) chk(t - tprev == per + 1, "R6 first paced byte", t - tprev, per + 1);
      if (i >= 3) begin
        int e = (i == drop) ? 2 * per : per;
        chk(t - tprev == e, (i == drop) ? "R7 slot after miss" : "R6/R8 paced spacing", t - tprev, e);
      end
      tprev = t;
      @(posedge clk);
      if (spd_flip && i == 2) speed_sel = 2'd2;
      @(negedge clk);
    end
    s_tvalid = 0;
    s_tlast  = 0;
    chk(s_tready == 0, "R9 idle cycle after last", s_tready, 0);
    @(negedge clk);
    chk(s_tready == 1, "R9 ready again", s_tready, 1);
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_tready == 1, "R1 ready idle", s_tready, 1);
    chk({o_strobe, o_sof, o_eof, o_underrun} == 0, "R1 outputs low",
        {o_strobe, o_sof, o_eof, o_underrun}, 0);

    speed_sel = 0; send_frame(8, 8'h10, 1, -1, 1, 0);
    speed_sel = 1; send_frame(6, 8'h40, 10, -1, 1, 0);
    speed_sel = 2; send_frame(4, 8'h60, 100, -1, 1, 0);
    speed_sel = 3; send_frame(4, 8'h70, 100, -1, 1, 0);

    // R8: speed flipped mid-frame keeps the 100 Mbps spacing
    speed_sel = 1; send_frame(6, 8'h80, 10, -1, 1, 1);

    // R7: missed slot
    speed_sel = 1; send_frame(6, 8'h90, 10, 4, 1, 0);
    chk(o_underrun == 1, "R7 underrun flagged", o_underrun, 1);
    send_frame(5, 8'hA0, 10, -1, 1, 0);
    chk(o_underrun == 0, "R7 underrun cleared", o_underrun, 0);
    speed_sel = 0; send_frame(5, 8'hA8, 1, 3, 1, 0);
    chk(o_underrun == 1, "R7 underrun full rate", o_underrun, 1);

    // R3: permit held low
    speed_sel = 1;
    tx_permit = 0;
    fork
      begin
        repeat (30) @(negedge clk);
        tx_permit = 1;
      end
    join_none
    send_frame(5, 8'hB0, 10, -1, 0, 0);
    chk(tx_permit == 1, "R3 frame finished after permit", tx_permit, 1);

    // R9/R5: one- and two-byte frames
    send_frame(1, 8'hC0, 10, -1, 1, 0);
    send_frame(2, 8'hD0, 10, -1, 1, 0);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 all bytes delivered", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule